// File: doc/BRIEF.md
# Dual-Rail Majority-Gate Ripple Adder

This block adds two W-bit operands and a carry-in. Inside the block every signal travels as a pair of wires: a true rail that holds the value and a false rail that holds its complement. The only logic gate is a three-input majority voter. An AND is a voter with one input tied low, and an OR is a voter with one input tied high. The datapath contains no inverter. A complement is obtained by swapping the two rails of a pair. The only place a value is inverted is the input register, which stores each operand bit together with its inverse.

The block has two register stages. The input stage holds the operands and carry-in in dual-rail form. The output stage holds the dual-rail sum and carry-out. Both ends use a valid/ready handshake. A word moves into the input stage on a clock edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, a held result stays frozen on the outputs. When both stages are full and the result is stalled, `in_ready` drops, so back-pressure passes upstream with no combinational path from `in_valid` to `out_valid`. Reset puts every rail into a null state in which both rails of each pair are 0.

Top module: `dr_maj_adder`

## Requirements
- R1: When `out_valid` is high, `sum_t` equals (a + b + cin) mod 2^W for the operands accepted in that transfer, and `sum_f` equals the bitwise complement of `sum_t`.
- R2: When `out_valid` is high, `cout_t` equals bit W of a + b + cin, and `cout_f` is its complement.
- R3: Whenever `out_valid` is high, every output rail pair is complementary: `sum_t ^ sum_f` is all ones and `cout_t ^ cout_f` is 1.
- R4: Synchronous reset (`rst` high at a rising edge) clears `out_valid` and drives all four output rail buses to 0, which is the null state.
- R5: With `out_ready` high, a word accepted at one rising edge appears with `out_valid` high after the following rising edge: two edges of latency in total.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `sum_t`, `sum_f`, `cout_t` and `cout_f` stay unchanged on the next edge.
- R7: `in_ready` is high whenever `out_valid` is low. It is low when both stages hold data and `out_ready` is low.
- R8: With `out_ready` held high, words accepted on consecutive edges come out on consecutive edges, in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, null state |
| in_valid | input | 1 | Operand word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| a_in | input | W | First operand, single rail |
| b_in | input | W | Second operand, single rail |
| cin | input | 1 | Carry-in, single rail |
| out_valid | output | 1 | Result present on the outputs |
| out_ready | input | 1 | Consumer takes the result this cycle |
| sum_t | output | W | Sum, true rail |
| sum_f | output | W | Sum, complement rail |
| cout_t | output | 1 | Carry-out, true rail |
| cout_f | output | 1 | Carry-out, complement rail |

## Verification
The complement check assumes that `out_valid` is high only after a word has come in through the handshake since reset. While `out_valid` is low, the rails may hold null or stale values and are not checked. The stall property assumes that the consumer only lowers `out_ready` between edges, so the bench changes every input at the falling edge. The bench releases reset before it offers any word. It keeps `in_valid` low when it is not sending, so no unintended word enters the pipeline.

// File: rtl/dr_adder_pkg.sv
package dr_adder_pkg;
  typedef struct packed {
    logic t;
    logic f;
  } rail_t;

  localparam logic TIE_AND = 1'b0;
  localparam logic TIE_OR  = 1'b1;
endpackage

// File: rtl/dr_maj3.sv
module dr_maj3 (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic y
);
  assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/dr_xor2.sv
module dr_xor2
  import dr_adder_pkg::*;
(
  input  rail_t x,
  input  rail_t y,
  output rail_t z
);
  logic p_xt_yf, p_xf_yt;
  logic s_xf_yt, s_xt_yf;

  // true rail: x.~y + ~x.y, voters tied low act as AND, tied high as OR
  dr_maj3 u_and0 (.a(x.t), .b(y.f), .c(TIE_AND), .y(p_xt_yf));
  dr_maj3 u_and1 (.a(x.f), .b(y.t), .c(TIE_AND), .y(p_xf_yt));
  dr_maj3 u_or0  (.a(p_xt_yf), .b(p_xf_yt), .c(TIE_OR), .y(z.t));

  // false rail: (~x + y).(x + ~y), rails swapped instead of inverted
  dr_maj3 u_or1  (.a(x.f), .b(y.t), .c(TIE_OR), .y(s_xf_yt));
  dr_maj3 u_or2  (.a(x.t), .b(y.f), .c(TIE_OR), .y(s_xt_yf));
  dr_maj3 u_and2 (.a(s_xf_yt), .b(s_xt_yf), .c(TIE_AND), .y(z.f));
endmodule

// File: rtl/dr_full_add.sv
module dr_full_add
  import dr_adder_pkg::*;
(
  input  rail_t a,
  input  rail_t b,
  input  rail_t ci,
  output rail_t s,
  output rail_t co
);
  rail_t half;

  // majority is self-dual: complement carry is the vote of complement rails
  dr_maj3 u_cy_t (.a(a.t), .b(b.t), .c(ci.t), .y(co.t));
  dr_maj3 u_cy_f (.a(a.f), .b(b.f), .c(ci.f), .y(co.f));

  dr_xor2 u_x0 (.x(a),    .y(b),  .z(half));
  dr_xor2 u_x1 (.x(half), .y(ci), .z(s));
endmodule

// File: rtl/dr_ripple.sv
module dr_ripple
  import dr_adder_pkg::*;
#(
  parameter int W = 8
) (
  input  rail_t [W-1:0] a,
  input  rail_t [W-1:0] b,
  input  rail_t         ci,
  output rail_t [W-1:0] s,
  output rail_t         co
);
  rail_t [W:0] chain;

  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    dr_full_add u_fa (
      .a  (a[i]),
      .b  (b[i]),
      .ci (chain[i]),
      .s  (s[i]),
      .co (chain[i+1])
    );
  end

  assign co = chain[W];
endmodule

// File: rtl/dr_maj_adder.sv
module dr_maj_adder
  import dr_adder_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cin,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] sum_t,
  output logic [W-1:0] sum_f,
  output logic         cout_t,
  output logic         cout_f
);
  localparam int NPAIR = W + 1;

  rail_t [W-1:0]     a_q, b_q;
  rail_t             c_q;
  logic              v1_q, v2_q;
  rail_t [W-1:0]     s_d;
  rail_t             co_d;
  rail_t [NPAIR-1:0] res_q;
  logic              adv2;

  assign adv2     = !v2_q || out_ready;
  assign in_ready = !v1_q || adv2;

  // input stage: the only place complements are made
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      a_q  <= '0;
      b_q  <= '0;
      c_q  <= '0;
    end else if (in_ready) begin
      v1_q <= in_valid;
      if (in_valid) begin
        for (int i = 0; i < W; i++) begin
          a_q[i] <= '{t: a_in[i], f: ~a_in[i]};
          b_q[i] <= '{t: b_in[i], f: ~b_in[i]};
        end
        c_q <= '{t: cin, f: ~cin};
      end
    end
  end

  dr_ripple #(.W(W)) u_rip (
    .a  (a_q),
    .b  (b_q),
    .ci (c_q),
    .s  (s_d),
    .co (co_d)
  );

  // output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      v2_q  <= 1'b0;
      res_q <= '0;
    end else if (adv2) begin
      v2_q <= v1_q;
      if (v1_q) res_q <= {co_d, s_d};
    end
  end

  assign out_valid = v2_q;
  for (genvar i = 0; i < W; i++) begin : g_out
    assign sum_t[i] = res_q[i].t;
    assign sum_f[i] = res_q[i].f;
  end
  assign cout_t = res_q[W].t;
  assign cout_f = res_q[W].f;
endmodule

// File: rtl/dr_maj_adder_chk.sv
module dr_maj_adder_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] sum_t,
  input logic [W-1:0] sum_f,
  input logic         cout_t,
  input logic         cout_f
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d)
      AST_NULL_AFTER_RESET: assert (!out_valid && sum_t == '0 && sum_f == '0 && !cout_t && !cout_f); // R4
  end

  AST_RAILS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((&(sum_t ^ sum_f)) && (cout_t ^ cout_f))); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(sum_t) && $stable(sum_f)
                                   && $stable(cout_t) && $stable(cout_f))); // R6

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R7
endmodule

bind dr_maj_adder dr_maj_adder_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .sum_t     (sum_t),
  .sum_f     (sum_f),
  .cout_t    (cout_t),
  .cout_f    (cout_f)
);

// File: tb/dr_maj_adder_tb.sv
module dr_maj_adder_tb;
  localparam int W = 8;
  localparam int NV = 10;
  localparam logic [2*W:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0}, {8'hFF, 8'h01, 1'b0}, {8'hFF, 8'hFF, 1'b1},
    {8'h80, 8'h80, 1'b0}, {8'hAA, 8'h55, 1'b1}, {8'hAA, 8'h55, 1'b0},
    {8'h0F, 8'hF0, 1'b1}, {8'h7F, 8'h00, 1'b1}, {8'h12, 8'h34, 1'b0},
    {8'h00, 8'h00, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         cin = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] sum_t, sum_f;
  logic         cout_t, cout_f;
  int           n_chk = 0, n_err = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  dr_maj_adder #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a_in(a_in), .b_in(b_in), .cin(cin), .out_valid(out_valid),
    .out_ready(out_ready), .sum_t(sum_t), .sum_f(sum_f),
    .cout_t(cout_t), .cout_f(cout_f)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_result(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    logic [W:0] e;
    e = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    chk("R1 valid", {31'd0, out_valid}, 32'd1);
    chk("R1 sum_t", {24'd0, sum_t}, {24'd0, e[W-1:0]});
    chk("R1 sum_f", {24'd0, sum_f}, {24'd0, ~e[W-1:0]});
    chk("R2 cout_t", {31'd0, cout_t}, {31'd0, e[W]});
    chk("R3 cout pair", {31'd0, cout_t ^ cout_f}, 32'd1);
  endtask

  task automatic present(input logic [2*W:0] v);
    {a_in, b_in, cin} = v;
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R4 reset state
    chk("R4 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R4 null rails", {14'd0, sum_t, sum_f, cout_t, cout_f}, 32'd0);
    rst = 1'b0;
    chk("R7 ready empty", {31'd0, in_ready}, 32'd1);

    // table walk, one word at a time; R5 latency
    for (int i = 0; i < NV; i++) begin
      present(VEC[i]);
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      chk("R5 not yet", {31'd0, out_valid}, 32'd0);
      @(posedge clk); @(negedge clk);
      chk_result(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]);
    end
    @(posedge clk); @(negedge clk);

    // R8 streaming at full rate
    for (int i = 0; i < 4; i++) begin
      present(VEC[i+2]);
      @(posedge clk); @(negedge clk);
      if (i > 0) chk_result(VEC[i+1][2*W:W+1], VEC[i+1][W:1], VEC[i+1][0]);
    end
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_result(VEC[5][2*W:W+1], VEC[5][W:1], VEC[5][0]);  // R8 last in order
    @(posedge clk); @(negedge clk);

    // R6 / R7 back-pressure
    out_ready = 1'b0;
    present(VEC[1]);
    @(posedge clk); @(negedge clk);
    present(VEC[2]);
    @(posedge clk); @(negedge clk);
    present(VEC[4]);
    chk_result(VEC[1][2*W:W+1], VEC[1][W:1], VEC[1][0]);
    chk("R7 ready full", {31'd0, in_ready}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk_result(VEC[1][2*W:W+1], VEC[1][W:1], VEC[1][0]);  // R6 held
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_result(VEC[2][2*W:W+1], VEC[2][W:1], VEC[2][0]);  // R8 order
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_result(VEC[4][2*W:W+1], VEC[4][W:1], VEC[4][0]);

    // R4 reset mid-flow
    present(VEC[2]);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R4 valid cleared", {31'd0, out_valid}, 32'd0);
    chk("R4 rails null", {14'd0, sum_t, sum_f, cout_t, cout_f}, 32'd0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R4 stays empty", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule